// File: doc/BRIEF.md
# Parity Small-Write Sequencer

This block carries out a single-block update in a disk array that keeps its redundancy on one dedicated parity disk. Each stripe holds four data blocks and one parity block. A requester hands over a stripe number and the index of the data disk to be overwritten, then streams the replacement block one word at a time. The sequencer makes four block accesses, strictly one after another. It reads the old data block from the chosen data disk, reads the old parity block, writes the new data block, and writes the new parity block. It then reports completion, with an error flag, on two plain status pins.

New parity is built one word at a time as old parity XOR old data XOR new data. The old data block and the old parity block are held in two internal word buffers, each the size of one block. Each new-data word is passed straight through to the data disk. As it passes, it is folded into the parity buffer in place, so no third buffer is needed. Every update touches the parity disk, so the sequencer accepts only one request at a time.

Both disk sides use the same protocol. A request level names the block and stays high until the disk raises a one-cycle acknowledge, which may carry an error. Block words move on valid/ready streams. The new-data input stream is back-pressured directly by the data disk: a word moves only in a cycle where both the requester's valid and the disk's ready are high. The requester must not make its valid depend on ready.

Top module: `raid4_rmw_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `dd_req`, `pd_req`, `resp_done`, `nd_ready`, `dd_rready` and `pd_rready` are all 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the cycle in which `resp_done` is high, and is high again in the following cycle.
- R3: The accesses are made in this order: read data disk, read parity disk, write data disk, write parity disk. At most one of `dd_req` and `pd_req` is high in any cycle. Each request, together with its write flag, holds steady until the cycle of its acknowledge and drops in the next cycle.
- R4: `dd_sel` and `dd_stripe` carry the accepted disk index and stripe number. `pd_stripe` carries the same stripe number.
- R5: Parity word i written to the parity disk equals old parity word i XOR old data word i XOR new data word i. Words are sent in index order 0 to BLK_WORDS-1, and the new data words reach the data disk unchanged and in order.
- R6: `nd_ready` can be high only while the data-disk write is in progress and fewer than BLK_WORDS words have moved. In that window it follows `dd_wready`, and `dd_wvalid` follows `nd_valid`. Exactly BLK_WORDS new words are consumed per successful update.
- R7: `dd_rready` and `pd_rready` are high only during the matching read access, until BLK_WORDS words have been taken.
- R8: The parity write request does not rise until all BLK_WORDS new-data words have moved and the data disk has acknowledged without error.
- R9: An acknowledge with its error bit set ends the update. In the next cycle `resp_done` and `resp_err` are both 1, and no further disk request is issued for that update.
- R10: An acknowledge without error that arrives before BLK_WORDS words of that access have moved is treated exactly as an error acknowledge (R9). The beat count is taken from earlier cycles only.
- R11: `resp_done` is a one-cycle pulse in the cycle after the final acknowledge. `resp_err` is 0 with it on success and is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_stripe | input | STRIPE_W | Stripe number of the update |
| req_disk | input | DSEL_W | Data disk index of the update |
| nd_valid | input | 1 | New data word valid |
| nd_ready | output | 1 | New data word taken |
| nd_data | input | WORD_W | New data word |
| resp_done | output | 1 | Update finished (pulse) |
| resp_err | output | 1 | Update ended with an error |
| dd_req | output | 1 | Data disk access request |
| dd_we | output | 1 | Data disk access is a write |
| dd_sel | output | DSEL_W | Data disk index |
| dd_stripe | output | STRIPE_W | Data disk stripe number |
| dd_ack | input | 1 | Data disk access finished |
| dd_err | input | 1 | Data disk reports an error with the acknowledge |
| dd_rvalid | input | 1 | Data disk read word valid |
| dd_rready | output | 1 | Data disk read word accepted |
| dd_rdata | input | WORD_W | Data disk read word |
| dd_wvalid | output | 1 | Data disk write word valid |
| dd_wready | input | 1 | Data disk takes the write word |
| dd_wdata | output | WORD_W | Data disk write word |
| pd_req | output | 1 | Parity disk access request |
| pd_we | output | 1 | Parity disk access is a write |
| pd_stripe | output | STRIPE_W | Parity disk stripe number |
| pd_ack | input | 1 | Parity disk access finished |
| pd_err | input | 1 | Parity disk reports an error with the acknowledge |
| pd_rvalid | input | 1 | Parity disk read word valid |
| pd_rready | output | 1 | Parity disk read word accepted |
| pd_rdata | input | WORD_W | Parity disk read word |
| pd_wvalid | output | 1 | Parity disk write word valid |
| pd_wready | input | 1 | Parity disk takes the write word |
| pd_wdata | output | WORD_W | Parity disk write word |

## Verification
Some rules are checked on every cycle. These are the exclusivity and holding of the two disk requests, the idle-only `req_ready`, the confinement of the read and new-data ready signals to their own access, the single-cycle response, the immediate stop after an error acknowledge, and the rule that a parity write only follows a clean data-write acknowledge. Other behaviour can only be shown by the bench's scenarios. These cover the arithmetic result of the parity update, the exact access order and addressing, and the number of new words consumed. They also cover the effect of stalls on both disks and the requester, and the treatment of each injected error or early acknowledge, for every disk and stripe of a small array.

// File: rtl/raid4_rmw_pkg.sv
package raid4_rmw_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD_DAT = 3'd1,
    S_RD_PAR = 3'd2,
    S_WR_DAT = 3'd3,
    S_WR_PAR = 3'd4,
    S_RESP   = 3'd5
  } rmw_state_e;

  // next access in the fixed order; the last access leads to the response
  function automatic rmw_state_e after_access(rmw_state_e s);
    case (s)
      S_RD_DAT: return S_RD_PAR;
      S_RD_PAR: return S_WR_DAT;
      S_WR_DAT: return S_WR_PAR;
      default:  return S_RESP;
    endcase
  endfunction

endpackage

// File: rtl/r4_word_buf.sv
module r4_word_buf #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(gi))) cells[gi] <= wr_word;
    end
  end

  // an index past the block (counter at its end) reads as zero
  assign rd_word = (int'(rd_idx) < DEPTH) ? cells[rd_idx] : '0;

endmodule

// File: rtl/r4_beat_cnt.sv
module r4_beat_cnt #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (inc && !full) cnt <= cnt + CNT_W'(1);
  end

  assign full = (cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/r4_seq_fsm.sv
module r4_seq_fsm
  import raid4_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       dd_ack,
  input  logic       dd_err,
  input  logic       pd_ack,
  input  logic       pd_err,
  input  logic       blk_full,
  output rmw_state_e state,
  output logic       leave,
  output logic       err_q
);

  rmw_state_e nxt;
  logic       acc_ack;
  logic       acc_err;
  logic       acc_fail;

  always_comb begin
    acc_ack = 1'b0;
    acc_err = 1'b0;
    case (state)
      S_RD_DAT, S_WR_DAT: begin acc_ack = dd_ack; acc_err = dd_err; end
      S_RD_PAR, S_WR_PAR: begin acc_ack = pd_ack; acc_err = pd_err; end
      default: ;
    endcase
    // an acknowledge before the whole block moved is a failure too
    acc_fail = acc_ack && (acc_err || !blk_full);
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (req_fire) nxt = S_RD_DAT;
      S_RESP: nxt = S_IDLE;
      default: if (acc_ack) nxt = acc_fail ? S_RESP : after_access(state);
    endcase
  end

  assign leave = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      err_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && req_fire) err_q <= 1'b0;
      else if (acc_fail)               err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/raid4_rmw_seq.sv
module raid4_rmw_seq
  import raid4_rmw_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  parameter int STRIPE_W  = 16,
  parameter int NUM_DATA  = 4,
  localparam int DSEL_W   = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [STRIPE_W-1:0] req_stripe,
  input  logic [DSEL_W-1:0]   req_disk,
  input  logic                nd_valid,
  output logic                nd_ready,
  input  logic [WORD_W-1:0]   nd_data,
  output logic                resp_done,
  output logic                resp_err,
  output logic                dd_req,
  output logic                dd_we,
  output logic [DSEL_W-1:0]   dd_sel,
  output logic [STRIPE_W-1:0] dd_stripe,
  input  logic                dd_ack,
  input  logic                dd_err,
  input  logic                dd_rvalid,
  output logic                dd_rready,
  input  logic [WORD_W-1:0]   dd_rdata,
  output logic                dd_wvalid,
  input  logic                dd_wready,
  output logic [WORD_W-1:0]   dd_wdata,
  output logic                pd_req,
  output logic                pd_we,
  output logic [STRIPE_W-1:0] pd_stripe,
  input  logic                pd_ack,
  input  logic                pd_err,
  input  logic                pd_rvalid,
  output logic                pd_rready,
  input  logic [WORD_W-1:0]   pd_rdata,
  output logic                pd_wvalid,
  input  logic                pd_wready,
  output logic [WORD_W-1:0]   pd_wdata
);

  localparam int IDX_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam int CNT_W = $clog2(BLK_WORDS + 1);

  rmw_state_e          state;
  logic                leave;
  logic                err_q;
  logic [CNT_W-1:0]    cnt;
  logic                blk_full;
  logic                req_fire;
  logic [STRIPE_W-1:0] stripe_q;
  logic [DSEL_W-1:0]   disk_q;

  logic                rd_beat_d, rd_beat_p, wr_beat_d, wr_beat_p, beat;
  logic [IDX_W-1:0]    widx;
  logic [WORD_W-1:0]   dbuf_word, pbuf_word, pbuf_in;
  logic                pbuf_we;

  assign req_ready = (state == S_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stripe_q <= '0;
      disk_q   <= '0;
    end else if (req_fire) begin
      stripe_q <= req_stripe;
      disk_q   <= req_disk;
    end
  end

  r4_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .dd_ack   (dd_ack),
    .dd_err   (dd_err),
    .pd_ack   (pd_ack),
    .pd_err   (pd_err),
    .blk_full (blk_full),
    .state    (state),
    .leave    (leave),
    .err_q    (err_q)
  );

  r4_beat_cnt #(.DEPTH(BLK_WORDS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (leave),
    .inc   (beat),
    .cnt   (cnt),
    .full  (blk_full)
  );

  assign widx = cnt[IDX_W-1:0];

  // disk request side
  assign dd_req    = (state == S_RD_DAT) || (state == S_WR_DAT);
  assign dd_we     = (state == S_WR_DAT);
  assign dd_sel    = disk_q;
  assign dd_stripe = stripe_q;
  assign pd_req    = (state == S_RD_PAR) || (state == S_WR_PAR);
  assign pd_we     = (state == S_WR_PAR);
  assign pd_stripe = stripe_q;

  // read streams fill the buffers
  assign dd_rready = (state == S_RD_DAT) && !blk_full;
  assign pd_rready = (state == S_RD_PAR) && !blk_full;
  assign rd_beat_d = dd_rvalid && dd_rready;
  assign rd_beat_p = pd_rvalid && pd_rready;

  // new data passes through to the data disk, back-pressured by it
  assign dd_wvalid = (state == S_WR_DAT) && !blk_full && nd_valid;
  assign nd_ready  = (state == S_WR_DAT) && !blk_full && dd_wready;
  assign dd_wdata  = nd_data;
  assign wr_beat_d = dd_wvalid && dd_wready;

  // finished parity leaves from the parity buffer
  assign pd_wvalid = (state == S_WR_PAR) && !blk_full;
  assign pd_wdata  = pbuf_word;
  assign wr_beat_p = pd_wvalid && pd_wready;

  assign beat = rd_beat_d || rd_beat_p || wr_beat_d || wr_beat_p;

  // parity buffer: loaded with old parity, then updated in place
  assign pbuf_we = rd_beat_p || wr_beat_d;
  assign pbuf_in = rd_beat_p ? pd_rdata : (pbuf_word ^ dbuf_word ^ nd_data);

  r4_word_buf #(.WORD_W(WORD_W), .DEPTH(BLK_WORDS)) u_dbuf (
    .clk     (clk),
    .wr_en   (rd_beat_d),
    .wr_idx  (widx),
    .wr_word (dd_rdata),
    .rd_idx  (widx),
    .rd_word (dbuf_word)
  );

  r4_word_buf #(.WORD_W(WORD_W), .DEPTH(BLK_WORDS)) u_pbuf (
    .clk     (clk),
    .wr_en   (pbuf_we),
    .wr_idx  (widx),
    .wr_word (pbuf_in),
    .rd_idx  (widx),
    .rd_word (pbuf_word)
  );

  assign resp_done = (state == S_RESP);
  assign resp_err  = (state == S_RESP) && err_q;

endmodule

// File: rtl/r4_rmw_checker.sv
module r4_rmw_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic nd_ready,
  input logic resp_done,
  input logic resp_err,
  input logic dd_req,
  input logic dd_we,
  input logic dd_ack,
  input logic dd_err,
  input logic dd_rready,
  input logic pd_req,
  input logic pd_we,
  input logic pd_ack,
  input logic pd_err,
  input logic pd_rready
);

  // set by a clean data-write acknowledge, cleared by a new request
  logic wr_data_ok;
  always_ff @(posedge clk) begin
    if (!rst_n)                                      wr_data_ok <= 1'b0;
    else if (req_valid && req_ready)                 wr_data_ok <= 1'b0;
    else if (dd_req && dd_we && dd_ack && !dd_err)   wr_data_ok <= 1'b1;
  end

  assert_one_disk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dd_req, pd_req}));

  assert_dd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_req && !dd_ack) |=> (dd_req && $stable(dd_we)));

  assert_pd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !pd_ack) |=> (pd_req && $stable(pd_we)));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dd_req && !pd_req && !resp_done));

  assert_rd_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_rready || pd_rready) |-> ((dd_rready && dd_req && !dd_we) || (pd_rready && pd_req && !pd_we)));

  assert_nd_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nd_ready |-> (dd_req && dd_we));

  assert_par_after_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_req && pd_we) |-> wr_data_ok);

  assert_stop_on_dd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_req && dd_ack && dd_err) |=> (!dd_req && !pd_req && resp_done && resp_err));

  assert_stop_on_pd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && pd_ack && pd_err) |=> (!dd_req && !pd_req && resp_done && resp_err));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_done);

endmodule

bind raid4_rmw_seq r4_rmw_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .nd_ready  (nd_ready),
  .resp_done (resp_done),
  .resp_err  (resp_err),
  .dd_req    (dd_req),
  .dd_we     (dd_we),
  .dd_ack    (dd_ack),
  .dd_err    (dd_err),
  .dd_rready (dd_rready),
  .pd_req    (pd_req),
  .pd_we     (pd_we),
  .pd_ack    (pd_ack),
  .pd_err    (pd_err),
  .pd_rready (pd_rready)
);

// File: tb/sim_raid4_rmw_seq.sv
module sim_raid4_rmw_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 8;
  localparam int BW = 4;
  localparam int SW = 2;
  localparam int ND = 4;
  localparam int NS = 1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SW-1:0] req_stripe = '0;
  logic [1:0] req_disk = '0;
  logic nd_valid = 1'b0;
  logic nd_ready;
  logic [WW-1:0] nd_data = '0;
  logic resp_done, resp_err;
  logic dd_req, dd_we, dd_rready, dd_wvalid;
  logic [1:0] dd_sel;
  logic [SW-1:0] dd_stripe;
  logic [WW-1:0] dd_wdata;
  logic dd_ack, dd_err, dd_rvalid, dd_wready;
  logic [WW-1:0] dd_rdata;
  logic pd_req, pd_we, pd_rready, pd_wvalid;
  logic [SW-1:0] pd_stripe;
  logic [WW-1:0] pd_wdata;
  logic pd_ack, pd_err, pd_rvalid, pd_wready;
  logic [WW-1:0] pd_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  raid4_rmw_seq #(.WORD_W(WW), .BLK_WORDS(BW), .STRIPE_W(SW), .NUM_DATA(ND)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_stripe(req_stripe), .req_disk(req_disk),
    .nd_valid(nd_valid), .nd_ready(nd_ready), .nd_data(nd_data),
    .resp_done(resp_done), .resp_err(resp_err),
    .dd_req(dd_req), .dd_we(dd_we), .dd_sel(dd_sel), .dd_stripe(dd_stripe),
    .dd_ack(dd_ack), .dd_err(dd_err), .dd_rvalid(dd_rvalid), .dd_rready(dd_rready),
    .dd_rdata(dd_rdata), .dd_wvalid(dd_wvalid), .dd_wready(dd_wready), .dd_wdata(dd_wdata),
    .pd_req(pd_req), .pd_we(pd_we), .pd_stripe(pd_stripe),
    .pd_ack(pd_ack), .pd_err(pd_err), .pd_rvalid(pd_rvalid), .pd_rready(pd_rready),
    .pd_rdata(pd_rdata), .pd_wvalid(pd_wvalid), .pd_wready(pd_wready), .pd_wdata(pd_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc_n = 0;
  logic [WW-1:0] dmem [ND][NS][BW];
  logic [WW-1:0] pmem [NS][BW];
  int log_n = 0;
  int log_typ [8];
  int log_dsk [8];
  int log_str [8];
  int inj_k = -1;
  int short_k = -1;
  bit stall_en = 1'b0;

  initial forever begin @(posedge clk); cyc_n++; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic init_mem();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < BW; w++) begin
        logic [WW-1:0] x;
        x = '0;
        for (int d = 0; d < ND; d++) begin
          dmem[d][s][w] = WW'(d*53 + s*29 + w*7 + 3);
          x ^= dmem[d][s][w];
        end
        pmem[s][w] = x;
      end
  endtask

  // disk models for both ports, driven at the falling edge
  initial begin
    bit d_act, d_acked, d_we_l, d_beat, p_act, p_acked, p_we_l, p_beat;
    int d_cnt, d_idx, d_sel_l, d_str_l, p_cnt, p_idx, p_str_l;
    logic [WW-1:0] d_word, p_word;
    d_act = 0; d_acked = 0; d_beat = 0; p_act = 0; p_acked = 0; p_beat = 0;
    d_cnt = 0; p_cnt = 0; d_idx = 0; p_idx = 0; d_sel_l = 0; d_str_l = 0; p_str_l = 0;
    d_we_l = 0; p_we_l = 0; d_word = '0; p_word = '0;
    dd_ack = 0; dd_err = 0; dd_rvalid = 0; dd_rdata = '0; dd_wready = 0;
    pd_ack = 0; pd_err = 0; pd_rvalid = 0; pd_rdata = '0; pd_wready = 0;
    forever begin
      @(negedge clk);
      if (d_beat) begin
        if (d_we_l) dmem[d_sel_l][d_str_l][d_cnt] = d_word;
        d_cnt++;
      end
      if (p_beat) begin
        if (p_we_l) pmem[p_str_l][p_cnt] = p_word;
        p_cnt++;
      end
      d_beat = 0; p_beat = 0;
      dd_ack = 0; dd_err = 0; dd_rvalid = 0; dd_wready = 0;
      pd_ack = 0; pd_err = 0; pd_rvalid = 0; pd_wready = 0;
      if (!dd_req) d_act = 0;
      else if (!d_act) begin
        d_act = 1; d_acked = 0; d_cnt = 0;
        d_sel_l = int'(dd_sel); d_str_l = int'(dd_stripe); d_we_l = dd_we; d_idx = log_n;
        if (log_n < 8) begin
          log_typ[log_n] = dd_we ? 2 : 0; log_dsk[log_n] = d_sel_l; log_str[log_n] = d_str_l;
        end
        log_n++;
      end
      if (!pd_req) p_act = 0;
      else if (!p_act) begin
        p_act = 1; p_acked = 0; p_cnt = 0;
        p_str_l = int'(pd_stripe); p_we_l = pd_we; p_idx = log_n;
        if (log_n < 8) begin
          log_typ[log_n] = pd_we ? 3 : 1; log_dsk[log_n] = -1; log_str[log_n] = p_str_l;
        end
        log_n++;
      end
      if (d_act && !d_acked) begin
        if (d_cnt == BW || (short_k == d_idx && d_cnt == 2)) begin
          dd_ack = 1; dd_err = (inj_k == d_idx); d_acked = 1;
        end else if (!(stall_en && (cyc_n % 3 == 1))) begin
          if (!d_we_l) begin dd_rvalid = 1; dd_rdata = dmem[d_sel_l][d_str_l][d_cnt]; end
          else dd_wready = 1;
        end
      end
      if (p_act && !p_acked) begin
        if (p_cnt == BW || (short_k == p_idx && p_cnt == 2)) begin
          pd_ack = 1; pd_err = (inj_k == p_idx); p_acked = 1;
        end else if (!(stall_en && (cyc_n % 5 == 2))) begin
          if (!p_we_l) begin pd_rvalid = 1; pd_rdata = pmem[p_str_l][p_cnt]; end
          else pd_wready = 1;
        end
      end
      #1;
      if (dd_rvalid && dd_rready) d_beat = 1;
      if (dd_wvalid && dd_wready) begin d_beat = 1; d_word = dd_wdata; end
      if (pd_rvalid && pd_rready) p_beat = 1;
      if (pd_wvalid && pd_wready) begin p_beat = 1; p_word = pd_wdata; end
    end
  end

  // one update; inj = access index acked with error, shrt = access index acked early
  task automatic do_write(input int s, input int d, input int seed, input int inj, input int shrt);
    logic [WW-1:0] nwd [BW];
    logic [WW-1:0] old_p [BW];
    logic [WW-1:0] old_d [BW];
    int wc, fail_k, exp_len;
    bit extra, bad_ready, got_err, exp_err;
    for (int w = 0; w < BW; w++) begin
      nwd[w] = WW'(s*17 + d*71 + w*13 + seed*5 + 9);
      old_p[w] = pmem[s][w];
      old_d[w] = dmem[d][s][w];
    end
    fail_k = (inj >= 0) ? inj : shrt;
    exp_err = (fail_k >= 0);
    exp_len = exp_err ? fail_k + 1 : 4;
    wc = 0; extra = 0; bad_ready = 0; got_err = 0;
    @(negedge clk);
    inj_k = inj; short_k = shrt; log_n = 0;
    req_valid = 1; req_stripe = SW'(s); req_disk = 2'(d);
    forever begin
      @(negedge clk);
      req_valid = 0;
      if (resp_done) begin got_err = resp_err; break; end
      if (req_ready) bad_ready = 1;
      if (wc < BW) begin
        nd_valid = !(stall_en && (cyc_n % 4 == 2));
        nd_data = nwd[wc];
      end else begin
        nd_valid = 1; nd_data = 8'hEE;
      end
      #1;
      if (nd_valid && nd_ready) begin
        if (wc < BW) wc++;
        else extra = 1;
      end
    end
    nd_valid = 0;
    check(!bad_ready, "R2 busy ready", int'(bad_ready), 0);
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready after done", int'(req_ready), 1);
    check(resp_done == 1'b0, "R11 done pulse width", int'(resp_done), 0);
    if (inj >= 0)       check(got_err == 1'b1, "R9 error reported", int'(got_err), 1);
    else if (shrt >= 0) check(got_err == 1'b1, "R10 early ack reported", int'(got_err), 1);
    else                check(got_err == 1'b0, "R11 clean response", int'(got_err), 0);
    check(log_n == exp_len, "R3 access count", log_n, exp_len);
    for (int i = 0; i < exp_len && i < 8; i++) begin
      check(log_typ[i] == i, "R3 access order", log_typ[i], i);
      check(log_str[i] == s, "R4 stripe", log_str[i], s);
      if (log_typ[i] == 0 || log_typ[i] == 2) check(log_dsk[i] == d, "R4 disk index", log_dsk[i], d);
    end
    check(!extra, "R6 no word past block", int'(extra), 0);
    if (exp_err && fail_k < 2)
      check(wc == 0, "R6 words consumed", wc, 0);
    else if (shrt == 2)
      check(wc == 2, "R10 words consumed", wc, 2);
    else
      check(wc == BW, "R6 words consumed", wc, BW);
    if (!exp_err) begin
      for (int w = 0; w < BW; w++) begin
        logic [WW-1:0] x;
        x = '0;
        for (int k = 0; k < ND; k++) x ^= dmem[k][s][w];
        check(dmem[d][s][w] == nwd[w], "R5 data word", int'(dmem[d][s][w]), int'(nwd[w]));
        check(pmem[s][w] == x, "R5 parity vs stripe", int'(pmem[s][w]), int'(x));
        check(pmem[s][w] == (old_p[w] ^ old_d[w] ^ nwd[w]), "R5 parity update",
              int'(pmem[s][w]), int'(old_p[w] ^ old_d[w] ^ nwd[w]));
      end
    end else if (fail_k <= 2) begin
      for (int w = 0; w < BW; w++) begin
        check(pmem[s][w] == old_p[w], "R8 parity untouched", int'(pmem[s][w]), int'(old_p[w]));
        if (fail_k < 2)
          check(dmem[d][s][w] == old_d[w], "R9 data untouched", int'(dmem[d][s][w]), int'(old_d[w]));
      end
    end
    inj_k = -1; short_k = -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    init_mem();
    nd_valid = 1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready idle", int'(req_ready), 1);
    check(!dd_req && !pd_req, "R1 no disk request", int'(dd_req) + int'(pd_req), 0);
    check(resp_done == 1'b0, "R1 no response", int'(resp_done), 0);
    check(nd_ready == 1'b0, "R6 idle new data blocked", int'(nd_ready), 0);
    check(!dd_rready && !pd_rready, "R7 idle read ready", int'(dd_rready) + int'(pd_rready), 0);
    nd_valid = 0;
    for (int it = 0; it < 2; it++) begin
      stall_en = (it == 1);
      for (int s = 0; s < NS; s++)
        for (int d = 0; d < ND; d++)
          do_write(s, d, it*16 + s*4 + d, -1, -1);
    end
    stall_en = 1;
    for (int k = 0; k < 4; k++) begin
      do_write(k % NS, (k + 1) % ND, 40 + k, k, -1);
      init_mem();
    end
    for (int k = 0; k < 4; k++) begin
      do_write((k + 2) % NS, (k + 3) % ND, 60 + k, -1, k);
      init_mem();
    end
    do_write(1, 2, 99, -1, -1);
    summary();
    $finish;
  end

endmodule